// File: doc/BRIEF.md
# Self-Loading Serial Segment Driver Core

This block is the digital core of a serial-in driver for 33 display segments. Serial data enters a 34-stage shift chain on each rising clock edge. A 33-bit word latch holds the pattern on display. Each latch bit enables one segment output. The outputs take their bits from the word stages through a fixed scrambled map. An active-low blank input gates every output.

Raising the load input copies word stages 1 to 33 into the latch and empties the chain. The overflow stage, which is the 34th, appears on `data_o`. Tying `data_o` back to `load_i` gives self-loading. A leading 1 marker then reaches the overflow stage exactly when the 33 data bits are in place, and the next edge performs the transfer with no load timing from the host.

Load is sampled at the rising edge. The transfer, the clear of the chain and the capture of that edge's serial bit all happen at the same edge. In self-load mode the word appears on the outputs at the 35th edge after the marker, and the bit presented at that edge becomes the first bit of the next word.

Top module: `seg_serial_driver`

## Requirements
- R1: While `rst_ni` is low, every shift stage and every latch bit is cleared, so `seg_o` is all zero and `data_o` is 0.
- R2: At a rising edge with `load_i` low, `data_i` enters stage 33, stage k moves to stage k-1 for k = 2..33, and stage 1 moves to the overflow stage. A bit shifted in at edge t is therefore in the overflow stage after edge t+33, and the first bit of a 33-bit word lands in stage 1.
- R3: At a rising edge with `load_i` high, stages 1..33 are copied into the latch, all other stages and the overflow stage become 0, and `data_i` of that edge is stored in stage 33.
- R4: A latch bit of 1 turns its output on (`seg_o` bit high). A latch bit of 0 turns it off.
- R5: While `blank_ni` is low, `seg_o` is all zero. The latch keeps its word, and the outputs show it again once `blank_ni` returns high.
- R6: Edges with `load_i` low leave the latch, and so `seg_o`, unchanged.
- R7: `data_o` shows the overflow stage. After a 1 followed by 33 more bits has been shifted into an empty chain, `data_o` is 1.
- R8: With `load_i` tied to `data_o`, a word sent as a 1 marker followed by 33 data bits is shown after the next edge (the 35th). `data_o` is then 0, and the bit sent at that edge starts the next word.
- R9: Output j (`seg_o[j-1]`) is driven by latch stage s with pairs j:s = 1:32, 2:21, 3:22, 4:23, 5:30, 6:13, 7:14, 8:15, 9:1, 10:33, 11:5, 12:6, 13:7, 14:28, 15:27, 16:31, 17:18, 18:2, 19:10, 20:26, 21:29, 22:3, 23:8, 24:9, 25:4, 26:11, 27:16, 28:17, 29:12, 30:19, 31:24, 32:25, 33:20.
- R10: With `load_i` driven externally, a 33-bit word with no marker is shown after an edge with `load_i` high that immediately follows its 33rd bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Serial data in |
| load_i | input | 1 | Transfer-and-clear request, sampled at the rising edge |
| blank_ni | input | 1 | Active-low blank of all outputs |
| data_o | output | 1 | Overflow stage, serial data out |
| seg_o | output | 33 | Segment enables, bit j-1 is output j |

## Verification
The hardest condition to reach is the edge where a self-load transfer coincides with the first bit of the following word. Data_out must feed back into load at that edge, and the latch, the clear and the new entry must all resolve together. The bench ties `load_i` to `data_o` and streams two words back to back, so that the second marker is presented on the transfer edge. A long externally controlled stream with no loads checks the 33-edge delay to `data_o` bit by bit. Walking-one words then check every entry of the output map.

// File: rtl/seg_drv_pkg.sv
`timescale 1ns/1ps
package seg_drv_pkg;
  localparam int unsigned SEG_COUNT = 33;

  // stage that feeds output j (1-based), scrambled wiring
  function automatic int unsigned seg_src(input int unsigned j);
    case (j)
      1: return 32;  2: return 21;  3: return 22;  4: return 23;
      5: return 30;  6: return 13;  7: return 14;  8: return 15;
      9: return 1;   10: return 33; 11: return 5;  12: return 6;
      13: return 7;  14: return 28; 15: return 27; 16: return 31;
      17: return 18; 18: return 2;  19: return 10; 20: return 26;
      21: return 29; 22: return 3;  23: return 8;  24: return 9;
      25: return 4;  26: return 11; 27: return 16; 28: return 17;
      29: return 12; 30: return 19; 31: return 24; 32: return 25;
      33: return 20;
      default: return j;
    endcase
  endfunction
endpackage

// File: rtl/seg_shift_chain.sv
`timescale 1ns/1ps
module seg_shift_chain #(
  parameter int unsigned N = 33
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       din_i,
  input  logic       clr_i,
  output logic [N:0] stage_o
);
  // stage_o[k] is word stage k, stage_o[0] is the overflow stage
  logic [N:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stage_q <= '0;
    else if (clr_i) stage_q <= {din_i, {N{1'b0}}};
    else            stage_q <= {din_i, stage_q[N:1]};
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/seg_word_latch.sv
`timescale 1ns/1ps
module seg_word_latch #(
  parameter int unsigned N = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] word_i,
  output logic [N-1:0] word_o
);
  logic [N-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/seg_out_map.sv
`timescale 1ns/1ps
module seg_out_map #(
  parameter int unsigned N = 33
) (
  input  logic [N-1:0] word_i,
  input  logic         blank_ni,
  output logic [N-1:0] seg_o
);
  for (genvar j = 0; j < N; j++) begin : g_out
    if (N == seg_drv_pkg::SEG_COUNT) begin : g_perm
      localparam int unsigned SRC = seg_drv_pkg::seg_src(j + 1) - 1;
      assign seg_o[j] = word_i[SRC] & blank_ni;
    end else begin : g_lin
      assign seg_o[j] = word_i[j] & blank_ni;
    end
  end
endmodule

// File: rtl/seg_serial_driver.sv
`timescale 1ns/1ps
module seg_serial_driver #(
  parameter int unsigned N_SEG = seg_drv_pkg::SEG_COUNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             load_i,
  input  logic             blank_ni,
  output logic             data_o,
  output logic [N_SEG-1:0] seg_o
);
  logic [N_SEG:0]   stage_q;
  logic [N_SEG-1:0] word_q;

  seg_shift_chain #(.N(N_SEG)) i_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (data_i),
    .clr_i   (load_i),
    .stage_o (stage_q)
  );

  seg_word_latch #(.N(N_SEG)) i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .word_i (stage_q[N_SEG:1]),
    .word_o (word_q)
  );

  seg_out_map #(.N(N_SEG)) i_map (
    .word_i   (word_q),
    .blank_ni (blank_ni),
    .seg_o    (seg_o)
  );

  assign data_o = stage_q[0];
endmodule

// File: rtl/seg_serial_driver_chk.sv
`timescale 1ns/1ps
module seg_serial_driver_chk #(
  parameter int unsigned N = 33
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         data_i,
  input logic         load_i,
  input logic         blank_ni,
  input logic         data_o,
  input logic [N-1:0] seg_o,
  input logic [N:0]   stage_q,
  input logic [N-1:0] word_q
);
  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (stage_q[N-1:0] == $past(stage_q[N:1])) && (stage_q[N] == $past(data_i)));

  p_load_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_q == $past(stage_q[N:1])) && (stage_q[N-1:0] == '0)
               && (stage_q[N] == $past(data_i)));

  p_on_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_ni |-> ($countones(seg_o) == $countones(word_q)));

  p_blank_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> (seg_o == '0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(word_q));

  p_dout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (data_o == $past(stage_q[1])));
endmodule

bind seg_serial_driver seg_serial_driver_chk #(.N(N_SEG)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .load_i   (load_i),
  .blank_ni (blank_ni),
  .data_o   (data_o),
  .seg_o    (seg_o),
  .stage_q  (stage_q),
  .word_q   (word_q)
);

// File: tb/test_seg_serial_driver.sv
`timescale 1ns/1ps
module test_seg_serial_driver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        data_i = 1'b0;
  logic        ext_ld = 1'b0;
  logic        self_mode = 1'b0;
  logic        blank_ni = 1'b1;
  logic        load_i;
  logic        data_o;
  logic [32:0] seg_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [32:0] cur_w = '0;
  logic [31:0] lf = 32'h1ace_b00c;
  logic [80:0] hist = '0;

  always #2 clk_i = ~clk_i;

  assign load_i = self_mode ? data_o : ext_ld;

  seg_serial_driver i_seg_serial_driver (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .load_i   (load_i),
    .blank_ni (blank_ni),
    .data_o   (data_o),
    .seg_o    (seg_o)
  );

  function automatic int src_of(input int j);
    int t [33] = '{32,21,22,23,30,13,14,15,1,33,5,6,7,28,27,31,18,2,10,26,
                   29,3,8,9,4,11,16,17,12,19,24,25,20};
    return t[j-1];
  endfunction

  function automatic logic [32:0] exp_seg(input logic [32:0] w, input logic bl);
    logic [32:0] r;
    for (int j = 1; j <= 33; j++) r[j-1] = w[src_of(j)-1] & bl;
    return r;
  endfunction

  task automatic check(input logic [32:0] act, input logic [32:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic d, input logic ld);
    data_i = d;
    ext_ld = ld;
    @(posedge clk_i);
    #1;
  endtask

  task automatic shift_word(input logic [32:0] w);
    for (int i = 0; i < 33; i++) tick(w[i], 1'b0);
  endtask

  task automatic step_lfsr();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  // self-load: marker + 33 bits, then transfer edge
  task automatic send_self(input logic [32:0] w, input string tag);
    tick(1'b1, 1'b0);
    shift_word(w);
    check({32'b0, data_o}, 33'd1, {tag, " R7 marker on data_o"});
    tick(1'b0, 1'b0);
    cur_w = w;
    check(seg_o, exp_seg(w, blank_ni), tag);
    check({32'b0, data_o}, 33'd0, {tag, " R3 chain cleared"});
  endtask

  // external load: 33 bits, load high at the 34th edge
  task automatic send_ext(input logic [32:0] w, input string tag);
    shift_word(w);
    check(seg_o, exp_seg(cur_w, blank_ni), "R6 latch held while shifting");
    tick(1'b0, 1'b1);
    cur_w = w;
    check(seg_o, exp_seg(w, blank_ni), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #5;
    check(seg_o, '0, "R1 outputs off in reset");
    check({32'b0, data_o}, '0, "R1 data_o low in reset");
    #4 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(seg_o, '0, "R1 outputs off after reset");

    // walking one, self-load: each output map entry
    self_mode = 1'b1;
    for (int s = 1; s <= 33; s++) send_self(33'd1 << (s - 1), "R9 R8 walking one");
    send_self('1, "R4 all on");
    send_self('0, "R4 all off");

    // back-to-back self-load: next marker on transfer edge
    begin
      logic [32:0] wa = 33'h1_2345_6789;
      logic [32:0] wb = 33'h0_f0f0_a5a5;
      tick(1'b1, 1'b0);
      shift_word(wa);
      tick(1'b1, 1'b0);
      check(seg_o, exp_seg(wa, 1'b1), "R8 word A shown");
      shift_word(wb);
      check({32'b0, data_o}, 33'd1, "R3 marker captured on transfer edge reaches data_o");
      tick(1'b0, 1'b0);
      cur_w = wb;
      check(seg_o, exp_seg(wb, 1'b1), "R3 word B shown");
    end

    // external-load patterns
    self_mode = 1'b0;
    for (int p = 0; p < 16; p++) begin
      step_lfsr();
      send_ext({lf[5], lf}, "R10 external word");
    end
    for (int s = 1; s <= 33; s += 8) send_ext(~(33'd1 << (s - 1)), "R9 walking zero");

    // serial delay through the chain, no loads
    tick(1'b0, 1'b1);
    cur_w = '0;
    for (int t = 1; t <= 70; t++) begin
      step_lfsr();
      hist[t] = lf[0];
      tick(lf[0], 1'b0);
      check({32'b0, data_o}, {32'b0, (t >= 34) ? hist[t-33] : 1'b0}, "R2 data_o delay");
    end
    check(seg_o, '0, "R6 latch held through long stream");
    begin
      logic [32:0] w;
      for (int k = 1; k <= 33; k++) w[k-1] = hist[37+k];
      tick(1'b0, 1'b1);
      cur_w = w;
      check(seg_o, exp_seg(w, 1'b1), "R3 latch takes stages 1..33");
      check({32'b0, data_o}, '0, "R3 overflow cleared");
    end

    // blanking
    #1 blank_ni = 1'b0;
    #1 check(seg_o, '0, "R5 blank forces off");
    send_ext(33'h1_5555_aaaa, "R5 load while blanked");
    #1 blank_ni = 1'b1;
    #1 check(seg_o, exp_seg(33'h1_5555_aaaa, 1'b1), "R5 word back after blank");

    // reset mid-operation
    shift_word(33'h0_dead_beef);
    #1 rst_ni = 1'b0;
    #1 check(seg_o, '0, "R1 reset clears latch");
    check({32'b0, data_o}, '0, "R1 reset clears chain");
    #3 rst_ni = 1'b1;
    cur_w = '0;
    send_ext(33'h1_0000_0001, "R10 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule